// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block is the receive half of a classic byte-oriented serial port. It sits between a deserializer, which delivers whole characters and break detections, and the register read port a processor uses to fetch them. In queued mode, characters are held in a small first-in first-out store of `DEPTH` entries, 16 by default. In single-register mode, only the most recent character is kept. The block drives the line status bits that concern reception: data ready, overrun and break. It also drives a trigger flag, raised when the fill level reaches a programmable threshold, and a timeout flag, raised when characters have waited too long without any new arrival or any read.

The idle timeout is measured in character times. The character time comes from the 16x baud enable and from the current line format. A character of F bits lasts `TICKS_PER_BIT * F` enables. The timeout fires after `TIMEOUT_CHARS` such characters, which is 4 by default.

Data enters through plain strobes. A deserializer cannot be held off, so there is no back-pressure toward it. When the queue has no room, a full queue sets the overrun bit instead of stalling the source. Reads are one-cycle strobes. The byte returned is presented on `rd_data` in the same cycle as `rd_en`.

Top module: `rxq_core`

## Requirements
- R1: In queued mode, characters are read out in arrival order. `rd_data` shows the oldest stored character whenever the queue is not empty, and `fifo_count` gives the occupancy, from 0 to `DEPTH`.
- R2: A character or break that arrives in queued mode when the queue is full, with no read in the same cycle, is discarded. The stored contents and count stay unchanged, and `overrun` is set on the next edge.
- R3: `lsr_rd` clears `overrun` and `brk_flag` on the next edge. A new overrun or break in the same cycle takes priority and leaves the bit set.
- R4: `fcr_trig_sel` selects the trigger threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. In queued mode, `trig_hit` is `data_ready` AND (`fifo_count` >= threshold). In single-register mode, `trig_hit` equals `data_ready`.
- R5: In queued mode, every arriving character or break restarts the idle timer, whether or not it is stored. `timeout_pend` is set at the edge of the `TICKS_PER_BIT*TIMEOUT_CHARS*F`-th `baud16_tick` after the restart, provided the queue is not empty and nothing restarted or cancelled the timer in between. The timer does not count `baud16_tick` in the restart cycle itself.
- R6: F, the character length in bits, is 1 + (5 + `lcr_cfg[1:0]`) + `lcr_cfg[3]` + (`lcr_cfg[2]` ? 2 : 1). This gives a range of 7 to 12 bits.
- R7: In queued mode, every `rd_en` clears `timeout_pend`. A read that leaves at least one character stored restarts the timer. A read that leaves the queue empty clears `data_ready` and `brk_flag`.
- R8: A read of an empty queue returns 0x00 and leaves the count at 0 and `data_ready` low.
- R9: `brk_det` stores a 0x00 character, in the queue or in the single register. It sets both `brk_flag` and `data_ready`. A `rx_valid` in the same cycle is absorbed, so one 0x00 character is stored.
- R10: A `fcr_wr` with `fcr_rx_clear` set, or with `fcr_fifo_en` different from the current mode, empties the queue. It also clears `data_ready`, `brk_flag` and `timeout_pend` and cancels the timer. Any character or read in that cycle is ignored.
- R11: In single-register mode, a character that arrives while `data_ready` is set, with no read in the same cycle, overwrites the register and sets `overrun`. A read returns the register and clears `data_ready` and `brk_flag`.
- R12: A read and an arrival in the same cycle are both carried out. The count stays the same, including when the queue is full.
- R13: After reset, the block is in single-register mode with threshold 1. All flags are low, the count is 0 and `rd_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on `rx_byte` |
| rx_byte | input | 8 | Received character |
| brk_det | input | 1 | One-cycle strobe: a break was detected on the line |
| rd_en | input | 1 | One-cycle strobe: read of the data register |
| rd_data | output | 8 | Byte returned by a data read (oldest entry, 0x00 when empty, or the single register) |
| lsr_rd | input | 1 | One-cycle strobe: read of the line status, clears overrun and break |
| fcr_wr | input | 1 | Write strobe for the queue control fields below |
| fcr_fifo_en | input | 1 | 1 selects queued mode, 0 selects single-register mode |
| fcr_rx_clear | input | 1 | Empty the queue on this write |
| fcr_trig_sel | input | 2 | Trigger threshold code |
| lcr_cfg | input | 4 | Line format: [1:0] data bits minus 5, [2] two stop bits, [3] parity present |
| baud16_tick | input | 1 | Enable at 16 times the bit rate |
| data_ready | output | 1 | At least one character is waiting |
| overrun | output | 1 | A character was lost |
| brk_flag | output | 1 | A break character has been received |
| trig_hit | output | 1 | Fill level has reached the threshold |
| timeout_pend | output | 1 | Idle timeout has expired with characters waiting |
| fifo_count | output | $clog2(DEPTH+1) | Number of stored characters |

## Verification
Every status flag and `fifo_count` is registered, so each changes on the first rising edge that samples the strobe causing it. `rd_data` is decoded from stored state and follows that same edge. `timeout_pend` is the one delayed result: it rises on the edge that samples the last of the `TICKS_PER_BIT*TIMEOUT_CHARS*F` enables after a restart. A reference model updates its state on every rising edge from the same inputs. Outputs are sampled one time unit after each edge, while inputs change only after that sample, so each comparison sees the first cycle in which a result is due. Directed checks count enables exactly on both sides of the timeout edge, for the shortest and the longest frame.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  // Threshold in characters for a trigger code.
  function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
    case (trig_sel_e'(sel))
      TRIG_1:  return 5'd1;
      TRIG_4:  return 5'd4;
      TRIG_8:  return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // Bits per character: start + data + optional parity + stop.
  function automatic logic [3:0] frame_bits(input logic [3:0] cfg);
    logic [3:0] stop_bits;
    stop_bits = cfg[2] ? 4'd2 : 4'd1;
    return 4'd1 + (4'd5 + {2'b00, cfg[1:0]}) + {3'b000, cfg[3]} + stop_bits;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
  logic [CW-1:0] cnt_q;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr_q + AW'(1);
      assign rptr_nx = rptr_q + AW'(1);
    end else begin : g_wrap
      assign wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
      assign rptr_nx = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_nx;
      if (pop)  rptr_q <= rptr_nx;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R2
  store_no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> !full);

  // R1
  store_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TICKS_PER_BIT = 16,
  parameter int CHARS         = 4,
  parameter int MAX_BITS      = 12,
  localparam int PW           = $clog2(TICKS_PER_BIT * MAX_BITS),
  localparam int QW           = (CHARS > 1) ? $clog2(CHARS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       cancel,
  input  logic       tick,
  input  logic [3:0] frame_bits,
  output logic       expire
);

  logic          run_q;
  logic [PW-1:0] pul_q;
  logic [QW-1:0] chr_q;
  logic [31:0]   lim32;
  logic          pul_last, chr_last;

  assign lim32    = 32'(frame_bits) * 32'(TICKS_PER_BIT) - 32'd1;
  assign pul_last = (pul_q == lim32[PW-1:0]);
  assign chr_last = (chr_q == QW'(CHARS - 1));
  assign expire   = run_q && tick && !restart && !cancel && pul_last && chr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pul_q <= '0;
      chr_q <= '0;
    end else if (cancel) begin
      run_q <= 1'b0;
      pul_q <= '0;
      chr_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1;
      pul_q <= '0;
      chr_q <= '0;
    end else if (run_q && tick) begin
      if (pul_last) begin
        pul_q <= '0;
        if (chr_last) begin
          run_q <= 1'b0;
          chr_q <= '0;
        end else begin
          chr_q <= chr_q + QW'(1);
        end
      end else begin
        pul_q <= pul_q + PW'(1);
      end
    end
  end

  // R5
  timer_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run_q);

  // R10
  timer_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |=> !run_q);

endmodule

// File: rtl/rxq_trig_cmp.sv
module rxq_trig_cmp
  import rxq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic [1:0]    sel,
  input  logic [CW-1:0] count,
  input  logic          fifo_mode,
  input  logic          ready,
  output logic          hit
);

  logic [31:0] need;

  assign need = 32'(trig_bytes(sel));
  assign hit  = ready && (!fifo_mode || (32'(count) >= need));

endmodule

// File: rtl/rxq_core.sv
module rxq_core
  import rxq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TIMEOUT_CHARS = 4,
  localparam int CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          brk_det,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          lsr_rd,
  input  logic          fcr_wr,
  input  logic          fcr_fifo_en,
  input  logic          fcr_rx_clear,
  input  logic [1:0]    fcr_trig_sel,
  input  logic [3:0]    lcr_cfg,
  input  logic          baud16_tick,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_flag,
  output logic          trig_hit,
  output logic          timeout_pend,
  output logic [CW-1:0] fifo_count
);

  logic          fifo_en_q;
  logic [1:0]    trig_q;
  byte_t         hold_q;
  logic          dr_q, ovr_q, brk_q, pend_q;

  logic          fcr_flush, live, in_any;
  byte_t         in_byte;
  logic          f_push, f_pop, f_drop, f_store_push;
  logic          h_push, h_rd, rd_emptied, ovr_set;
  logic          t_restart, t_expire;
  logic [3:0]    fbits;
  byte_t         head;
  logic [CW-1:0] cnt;
  logic          full, empty;

  // Event decode: a queue flush masks every other event of its cycle.
  assign fcr_flush    = fcr_wr && (fcr_rx_clear || (fcr_fifo_en != fifo_en_q));
  assign live         = !fcr_flush;
  assign in_any       = rx_valid || brk_det;
  assign in_byte      = brk_det ? 8'h00 : rx_byte;

  assign f_push       = fifo_en_q && in_any && live;
  assign f_pop        = fifo_en_q && rd_en && !empty && live;
  assign f_drop       = f_push && full && !f_pop;
  assign f_store_push = f_push && !f_drop;
  assign rd_emptied   = fifo_en_q && rd_en && live &&
                        (empty || ((cnt == CW'(1)) && !f_store_push));

  assign h_push       = !fifo_en_q && in_any && live;
  assign h_rd         = !fifo_en_q && rd_en && live;
  assign ovr_set      = f_drop || (h_push && dr_q && !rd_en);

  assign t_restart    = f_push || (f_pop && (cnt > CW'(1)));
  assign fbits        = frame_bits(lcr_cfg);

  rxq_store #(
    .DEPTH (DEPTH),
    .W     (8)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fcr_flush),
    .push  (f_store_push),
    .pop   (f_pop),
    .wdata (in_byte),
    .head  (head),
    .count (cnt),
    .full  (full),
    .empty (empty)
  );

  rxq_idle_timer #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .CHARS         (TIMEOUT_CHARS),
    .MAX_BITS      (12)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (t_restart),
    .cancel     (fcr_flush),
    .tick       (baud16_tick),
    .frame_bits (fbits),
    .expire     (t_expire)
  );

  rxq_trig_cmp #(
    .CW (CW)
  ) u_trig (
    .sel       (trig_q),
    .count     (cnt),
    .fifo_mode (fifo_en_q),
    .ready     (dr_q),
    .hit       (trig_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      trig_q    <= 2'b00;
      hold_q    <= '0;
      dr_q      <= 1'b0;
      ovr_q     <= 1'b0;
      brk_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (fcr_wr) begin
        fifo_en_q <= fcr_fifo_en;
        trig_q    <= fcr_trig_sel;
      end

      if (h_push) hold_q <= in_byte;

      if (fcr_flush)                 dr_q <= 1'b0;
      else if (f_push || h_push)     dr_q <= 1'b1;
      else if (rd_emptied || h_rd)   dr_q <= 1'b0;

      if (fcr_flush)                          brk_q <= 1'b0;
      else if (brk_det)                       brk_q <= 1'b1;
      else if (lsr_rd || rd_emptied || h_rd)  brk_q <= 1'b0;

      if (ovr_set)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;

      if (fcr_flush)                 pend_q <= 1'b0;
      else if (fifo_en_q && rd_en)   pend_q <= 1'b0;
      else if (t_expire && !empty)   pend_q <= 1'b1;
    end
  end

  assign rd_data      = fifo_en_q ? (empty ? 8'h00 : head) : hold_q;
  assign data_ready   = dr_q;
  assign overrun      = ovr_q;
  assign brk_flag     = brk_q;
  assign timeout_pend = pend_q;
  assign fifo_count   = cnt;

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && in_any && live && full && !rd_en) |=>
      (overrun && fifo_count == CW'(DEPTH)));

  // R7
  read_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && rd_en) |=> !timeout_pend);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && rd_en && empty && !in_any && live) |=>
      (fifo_count == '0 && !data_ready && rd_data == 8'h00));

  // R9
  break_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_det && live) |=> (brk_flag && data_ready));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_flush |=> (fifo_count == '0 && !data_ready && !timeout_pend && !brk_flag));

  // R11
  hold_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_q && rx_valid && !brk_det && live && data_ready && !rd_en) |=>
      (overrun && rd_data == $past(rx_byte)));

  // R12
  push_pop_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && rx_valid && rd_en && !empty && live) |=>
      (fifo_count == $past(fifo_count)));

endmodule

// File: tb/rxq_core_bench.sv
module rxq_core_bench;
  import rxq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int TPB        = 16;
  localparam int TCH        = 4;
  localparam int CW         = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, brk_det = 0, rd_en = 0, lsr_rd = 0, fcr_wr = 0;
  logic fcr_fifo_en = 0, fcr_rx_clear = 0, baud16_tick = 0;
  logic [1:0] fcr_trig_sel = 0;
  logic [3:0] lcr_cfg = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] rd_data;
  logic data_ready, overrun, brk_flag, trig_hit, timeout_pend;
  logic [CW-1:0] fifo_count;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxq_core #(.DEPTH(DEPTH), .TICKS_PER_BIT(TPB), .TIMEOUT_CHARS(TCH)) u_rxq_core (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .brk_det(brk_det),
    .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr),
    .fcr_fifo_en(fcr_fifo_en), .fcr_rx_clear(fcr_rx_clear), .fcr_trig_sel(fcr_trig_sel),
    .lcr_cfg(lcr_cfg), .baud16_tick(baud16_tick), .data_ready(data_ready),
    .overrun(overrun), .brk_flag(brk_flag), .trig_hit(trig_hit),
    .timeout_pend(timeout_pend), .fifo_count(fifo_count)
  );

  // ---------------- reference model ----------------
  byte_t mq[$];
  byte_t m_hold;
  bit m_dr, m_ovr, m_brk, m_pend, m_en;
  logic [1:0] m_lvl;
  int m_rem;

  function automatic int bits_of(input logic [3:0] c);
    return 1 + 5 + int'(c[1:0]) + int'(c[3]) + (c[2] ? 2 : 1);
  endfunction

  function automatic int level_of(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_step();
    bit flush, anyin, popped, drop, restart, expire, oset;
    byte_t b;
    int c0;
    flush = fcr_wr && (fcr_rx_clear || (fcr_fifo_en != m_en));
    if (flush) begin
      mq.delete();
      m_dr = 0; m_brk = 0; m_pend = 0; m_rem = 0;
      m_en = fcr_fifo_en; m_lvl = fcr_trig_sel;
      if (lsr_rd) m_ovr = 0;
      return;
    end
    if (fcr_wr) m_lvl = fcr_trig_sel;
    anyin = rx_valid || brk_det;
    b = brk_det ? 8'h00 : rx_byte;
    if (m_en) begin
      c0 = mq.size();
      popped = rd_en && c0 > 0;
      drop = 0;
      if (popped) void'(mq.pop_front());
      if (anyin) begin
        if (c0 == DEPTH && !popped) drop = 1;
        else mq.push_back(b);
      end
      restart = anyin || (popped && c0 > 1);
      expire = !restart && baud16_tick && m_rem == 1;
      if (restart) m_rem = TPB * TCH * bits_of(lcr_cfg);
      else if (baud16_tick && m_rem > 0) m_rem--;
      if (rd_en) m_pend = 0;
      else if (expire && c0 > 0) m_pend = 1;
      if (anyin) m_dr = 1;
      else if (rd_en && mq.size() == 0) m_dr = 0;
      if (brk_det) m_brk = 1;
      else if (lsr_rd || (rd_en && mq.size() == 0)) m_brk = 0;
      if (drop) m_ovr = 1;
      else if (lsr_rd) m_ovr = 0;
    end else begin
      oset = anyin && m_dr && !rd_en;
      if (anyin) begin m_hold = b; m_dr = 1; end
      else if (rd_en) m_dr = 0;
      if (brk_det) m_brk = 1;
      else if (lsr_rd || rd_en) m_brk = 0;
      if (oset) m_ovr = 1;
      else if (lsr_rd) m_ovr = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_hold = 0; m_dr = 0; m_ovr = 0; m_brk = 0; m_pend = 0; m_en = 0;
      m_lvl = 0; m_rem = 0;
    end else begin
      model_step();
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    int e_data, e_trig;
    e_data = m_en ? ((mq.size() > 0) ? int'(mq[0]) : 0) : int'(m_hold);
    e_trig = int'(m_dr && (!m_en || mq.size() >= level_of(m_lvl)));
    chk(int'(rd_data) == e_data, "R1 rd_data", int'(rd_data), e_data);
    chk(int'(fifo_count) == mq.size(), "R12 fifo_count", int'(fifo_count), mq.size());
    chk(data_ready == m_dr, "R7 data_ready", int'(data_ready), int'(m_dr));
    chk(overrun == m_ovr, "R2 overrun", int'(overrun), int'(m_ovr));
    chk(brk_flag == m_brk, "R9 brk_flag", int'(brk_flag), int'(m_brk));
    chk(int'(trig_hit) == e_trig, "R4 trig_hit", int'(trig_hit), e_trig);
    chk(timeout_pend == m_pend, "R5 timeout_pend", int'(timeout_pend), int'(m_pend));
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    check_all();
    rx_valid = 0; brk_det = 0; rd_en = 0; lsr_rd = 0; fcr_wr = 0; fcr_rx_clear = 0;
  endtask

  task automatic step(input bit v, input byte_t b, input bit brk, input bit rd,
                      input bit lsr, input bit tk);
    rx_valid = v; rx_byte = b; brk_det = brk; rd_en = rd; lsr_rd = lsr; baud16_tick = tk;
    cyc();
  endtask

  task automatic fcr(input bit en, input bit clr, input logic [1:0] sel);
    fcr_wr = 1; fcr_fifo_en = en; fcr_rx_clear = clr; fcr_trig_sel = sel; baud16_tick = 0;
    cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R13 reset state
    chk(!data_ready && !overrun && !brk_flag && !trig_hit && !timeout_pend,
        "R13 flags after reset", int'({data_ready, overrun, brk_flag, trig_hit, timeout_pend}), 0);
    chk(fifo_count == 0 && rd_data == 0, "R13 count/data after reset", int'(rd_data), 0);

    // R11 single-register mode
    step(1, 8'hA5, 0, 0, 0, 0);
    chk(rd_data == 8'hA5 && data_ready, "R11 hold byte", int'(rd_data), 'hA5);
    step(1, 8'h3C, 0, 0, 0, 0);
    chk(overrun && rd_data == 8'h3C, "R11 overwrite sets overrun", int'(overrun), 1);
    step(0, 8'h00, 0, 1, 0, 0);
    chk(!data_ready, "R11 read clears ready", int'(data_ready), 0);
    step(0, 8'h00, 0, 0, 1, 0);
    chk(!overrun, "R3 lsr read clears overrun", int'(overrun), 0);
    step(0, 8'h00, 1, 0, 0, 0);
    chk(brk_flag && data_ready && rd_data == 0, "R9 break in hold mode", int'(brk_flag), 1);
    step(0, 8'h00, 0, 1, 0, 0);

    // queued mode
    fcr(1, 0, 2'b00);
    chk(fifo_count == 0, "R10 enable change flushes", int'(fifo_count), 0);
    step(1, 8'h11, 0, 0, 0, 0);
    step(1, 8'h22, 0, 0, 0, 0);
    step(1, 8'h33, 0, 0, 0, 0);
    chk(fifo_count == 3 && rd_data == 8'h11, "R1 order head", int'(rd_data), 'h11);
    step(0, 8'h00, 0, 1, 0, 0);
    chk(rd_data == 8'h22, "R1 second byte", int'(rd_data), 'h22);
    step(0, 8'h00, 0, 1, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0);
    step(0, 8'h00, 0, 1, 0, 0);
    chk(rd_data == 0 && fifo_count == 0 && !data_ready, "R8 empty read", int'(rd_data), 0);

    // R4 trigger levels
    fcr(1, 0, 2'b01);
    for (int i = 0; i < 3; i++) step(1, byte_t'(8'h40 + i), 0, 0, 0, 0);
    chk(!trig_hit, "R4 below 4", int'(trig_hit), 0);
    step(1, 8'h43, 0, 0, 0, 0);
    chk(trig_hit, "R4 at 4", int'(trig_hit), 1);
    fcr(1, 0, 2'b10);
    chk(!trig_hit, "R4 level 8 not reached", int'(trig_hit), 0);
    fcr(1, 0, 2'b11);
    for (int i = 4; i < 16; i++) step(1, byte_t'(8'h40 + i), 0, 0, 0, 0);
    chk(trig_hit && fifo_count == 16, "R4 level 14 on full", int'(fifo_count), 16);

    // R2 overrun on full, R12 push with pop on full
    step(1, 8'hEE, 0, 0, 0, 0);
    chk(overrun && fifo_count == 16 && rd_data == 8'h40, "R2 drop on full", int'(rd_data), 'h40);
    step(1, 8'h77, 0, 1, 1, 0);
    chk(fifo_count == 16 && !overrun, "R12 push and pop on full", int'(fifo_count), 16);
    for (int i = 0; i < 15; i++) step(0, 8'h00, 0, 1, 0, 0);
    chk(rd_data == 8'h77 && fifo_count == 1, "R2 contents kept", int'(rd_data), 'h77);

    // R10 flush by clear bit
    step(1, 8'h01, 0, 0, 0, 0);
    fcr(1, 1, 2'b00);
    chk(fifo_count == 0 && !data_ready, "R10 clear bit flushes", int'(fifo_count), 0);

    // R9 break with same-cycle byte
    step(1, 8'h55, 1, 0, 0, 0);
    chk(fifo_count == 1 && rd_data == 0 && brk_flag, "R9 break stores zero", int'(rd_data), 0);
    step(0, 8'h00, 0, 1, 0, 0);
    chk(!brk_flag && !data_ready, "R7 emptying read clears flags", int'(brk_flag), 0);

    // R5 / R6 timeout, F = 7
    lcr_cfg = 4'h0;
    step(1, 8'h61, 0, 0, 0, 1);
    idle(TPB * TCH * 7 - 1);
    chk(!timeout_pend, "R6 no timeout one tick early (F=7)", int'(timeout_pend), 0);
    idle(1);
    chk(timeout_pend, "R5 timeout at limit (F=7)", int'(timeout_pend), 1);
    step(1, 8'h62, 0, 0, 0, 1);
    step(0, 8'h00, 0, 1, 0, 1);
    chk(!timeout_pend && fifo_count == 1, "R7 read clears timeout", int'(timeout_pend), 0);
    idle(TPB * TCH * 7 - 1);
    chk(!timeout_pend, "R7 restart after read", int'(timeout_pend), 0);
    idle(1);
    chk(timeout_pend, "R7 restarted timer expires", int'(timeout_pend), 1);

    // R6 longest frame, F = 12
    lcr_cfg = 4'hF;
    step(0, 8'h00, 0, 1, 0, 0);
    step(1, 8'h63, 0, 0, 0, 1);
    idle(TPB * TCH * 12 - 1);
    chk(!timeout_pend, "R6 no timeout one tick early (F=12)", int'(timeout_pend), 0);
    idle(1);
    chk(timeout_pend, "R6 timeout at limit (F=12)", int'(timeout_pend), 1);

    // R10 flush by leaving queued mode
    fcr(0, 0, 2'b00);
    chk(fifo_count == 0 && !timeout_pend, "R10 disable flushes", int'(timeout_pend), 0);
    lcr_cfg = 4'h0;
    fcr(1, 0, 2'b00);

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        fcr_wr = 1;
        fcr_fifo_en = ($urandom_range(0, 3) != 0);
        fcr_rx_clear = ($urandom_range(0, 3) == 0);
        fcr_trig_sel = 2'($urandom_range(0, 3));
      end
      step($urandom_range(0, 2) == 0, byte_t'($urandom_range(0, 255)),
           $urandom_range(0, 39) == 0, $urandom_range(0, 3) == 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1);
    end

    summary();
    $finish;
  end

endmodule